// File: doc/BRIEF.md
# Keyed instruction-memory write port

This block lets a processor place words into its separate instruction memory from the data side. It decodes three word registers on a small 32-bit I/O write bus: a key register, a pointer register and a data register. A data write passes through to the instruction-memory write interface only after the exact 32-bit key has been written to the key register. Any other value written there closes the port again.

Software first loads the pointer with the target byte address, writes the key, and then writes a stream of words to the data register. Each accepted word is written at the pointer and moves the pointer forward one word (4 bytes), so a program image can be written without reloading the address. Data writes made while the port is closed are dropped and leave the pointer where it was.

Top module: `imem_key_port`

## Requirements
- R1: A write of exactly 0x1337F7D1 to the key register (I/O offset 0x00) opens the port from the next cycle on.
- R2: A write of any other value to the key register closes the port from the next cycle on. This includes every value that differs from the key in a single bit.
- R3: A write to the pointer register (offset 0x04) loads all 32 bits of the written value into the pointer, and pm_addr shows it from the next cycle on.
- R4: While the port is open, a write to the data register (offset 0x08) raises pm_we in that same cycle. pm_addr then carries the current pointer and pm_wdata carries the full 32-bit written word.
- R5: After each accepted data write the pointer is 4 greater, modulo 2^32, so 0xFFFFFFFC advances to 0x00000000.
- R6: A data write while the port is closed gives no pm_we and leaves the pointer unchanged.
- R7: Only the three offsets 0x00, 0x04 and 0x08 are decoded. A write to any other io_addr value changes neither the lock state nor the pointer, and it gives no pm_we.
- R8: Reset leaves the port closed and the pointer at zero.
- R9: pm_we is high only in a cycle where io_wr is high. It is low whenever io_wr is low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one write per cycle it is high |
| io_addr | input | IO_AW (8) | I/O byte offset of the write |
| io_wdata | input | DATA_W (32) | I/O write data |
| pm_we | output | 1 | Instruction-memory write enable, high for the accepted cycle |
| pm_addr | output | PTR_W (32) | Instruction-memory byte address: the current pointer |
| pm_wdata | output | DATA_W (32) | Instruction-memory write data |

## Verification
The pointer is visible on pm_addr at all times. A wrong load or a wrong step therefore shows on the very next cycle, and the bench compares pm_addr against its own model on every write. The lock flag cannot be seen directly, so a wrong lock state appears only at the next data write, as a missing or unexpected pm_we. For that reason every key-register write and every stray-address write in the bench is followed by a data-register probe. The address sweep covers all 256 offsets with both the key value and a closing value, so a decode alias shows as a pointer change or as a flipped lock at the following probe.

// File: rtl/imkp_pkg.sv
package imkp_pkg;

  localparam int WORD_W     = 32;
  localparam int NUM_REGS   = 3;
  localparam int REG_STRIDE = 4;

  localparam int SEL_KEY  = 0;
  localparam int SEL_PTR  = 1;
  localparam int SEL_DATA = 2;

  localparam logic [WORD_W-1:0] OPEN_KEY = 32'h1337_F7D1;

  typedef struct packed {
    logic key;
    logic ptr;
    logic data;
  } reg_hit_t;

  function automatic logic key_matches(input logic [WORD_W-1:0] v);
    return (v ^ OPEN_KEY) == '0;
  endfunction

  function automatic logic [WORD_W-1:0] ptr_advance(input logic [WORD_W-1:0] p,
                                                    input logic [WORD_W-1:0] step);
    return p + step;
  endfunction

endpackage

// File: rtl/imkp_decode.sv
module imkp_decode
  import imkp_pkg::*;
#(
  parameter int IO_AW = 8
) (
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  output reg_hit_t         hit
);

  logic [NUM_REGS-1:0] match;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
    localparam logic [IO_AW-1:0] OFFS = IO_AW'(REG_STRIDE * i);
    assign match[i] = io_wr && (io_addr == OFFS);
  end

  assign hit.key  = match[SEL_KEY];
  assign hit.ptr  = match[SEL_PTR];
  assign hit.data = match[SEL_DATA];

  always_comb begin
    a_onehot_hit_r7: assert ($onehot0(match));
  end

endmodule

// File: rtl/imkp_lock.sv
module imkp_lock
  import imkp_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);

  logic key_ok;
  assign key_ok = key_matches(WORD_W'(wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= key_ok;
  end

  p_key_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata == DATA_W'(OPEN_KEY)) |=> unlocked);

  p_other_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata != DATA_W'(OPEN_KEY)) |=> !unlocked);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(unlocked));

endmodule

// File: rtl/imkp_pointer.sv
module imkp_pointer
  import imkp_pkg::*;
#(
  parameter int PTR_W = WORD_W,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [WORD_W-1:0] STEP_V = WORD_W'(STEP);

  logic [PTR_W-1:0] ptr_next;
  assign ptr_next = PTR_W'(ptr_advance(WORD_W'(ptr), STEP_V));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_next;
  end

  p_load_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == $past(load_val));

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(ptr));

  always_comb begin
    a_exclusive_r7: assert (!(load && step));
  end

endmodule

// File: rtl/imem_key_port.sv
module imem_key_port
  import imkp_pkg::*;
#(
  parameter int IO_AW  = 8,
  parameter int DATA_W = WORD_W,
  parameter int PTR_W  = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              pm_we,
  output logic [PTR_W-1:0]  pm_addr,
  output logic [DATA_W-1:0] pm_wdata
);

  localparam int WORD_BYTES = DATA_W / 8;

  reg_hit_t         hit;
  logic             unlocked;
  logic             data_accept;
  logic             data_drop;
  logic [PTR_W-1:0] ptr;

  imkp_decode #(.IO_AW(IO_AW)) u_decode (
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .hit     (hit)
  );

  imkp_lock #(.DATA_W(DATA_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (hit.key),
    .wdata    (io_wdata),
    .unlocked (unlocked)
  );

  assign data_accept = hit.data && unlocked;
  assign data_drop   = hit.data && !unlocked;

  imkp_pointer #(.PTR_W(PTR_W), .STEP(WORD_BYTES)) u_pointer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hit.ptr),
    .load_val (PTR_W'(io_wdata)),
    .step     (data_accept),
    .ptr      (ptr)
  );

  assign pm_we    = data_accept;
  assign pm_addr  = ptr;
  assign pm_wdata = io_wdata;

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |=> pm_addr == $past(pm_addr) + PTR_W'(WORD_BYTES));

  p_locked_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_drop |=> $stable(pm_addr));

  p_we_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> unlocked);

  p_we_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> io_wr);

  p_reset_state_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> (pm_addr == '0 && !unlocked));

endmodule

// File: tb/imem_key_port_test.sv
module imem_key_port_test;

  localparam logic [31:0] KEY = 32'h1337_F7D1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic        pm_we;
  logic [31:0] pm_addr;
  logic [31:0] pm_wdata;

  int checks = 0;
  int fails = 0;
  logic        m_open = 1'b0;
  logic [31:0] m_ptr = '0;

  always #5 clk = ~clk;

  imem_key_port uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [31:0] d, input string tag);
    logic exp_we;
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    #2;
    exp_we = (a == 8'h08) && m_open;
    chk(tag, {31'd0, pm_we}, {31'd0, exp_we});
    chk(tag, pm_addr, m_ptr);
    if (exp_we) chk(tag, pm_wdata, d);
    if (a == 8'h00) m_open = (d == KEY);
    else if (a == 8'h04) m_ptr = d;
    else if (a == 8'h08 && m_open) m_ptr = m_ptr + 32'd4;
    @(posedge clk);
    #1 io_wr = 1'b0;
    #1 chk(tag, pm_addr, m_ptr);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R8: reset state
    #12;
    chk("R8 we in reset", {31'd0, pm_we}, 32'd0);
    chk("R8 ptr in reset", pm_addr, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R8 ptr after reset", pm_addr, 32'd0);
    io_write(8'h08, 32'hAAAA_0001, "R8 closed after reset");

    // R3: full-width pointer loads
    io_write(8'h04, 32'hDEAD_BEEF, "R3");
    io_write(8'h04, 32'h0000_0100, "R3");

    // R6: locked data writes dropped
    for (int i = 0; i < 4; i++) io_write(8'h08, 32'h5500_0000 + i, "R6");

    // R1 and R4: open and stream words
    io_write(8'h00, KEY, "R1");
    for (int i = 0; i < 8; i++) io_write(8'h08, 32'hC0DE_0000 + i * 32'h1111, "R4");

    // R5: wrap of the pointer
    io_write(8'h04, 32'hFFFF_FFF8, "R5 load");
    for (int i = 0; i < 3; i++) io_write(8'h08, 32'h0F0F_0000 + i, "R5");
    chk("R5 wrapped", pm_addr, 32'h0000_0004);

    // R9: strobe low gives no write even at data offset while open
    @(negedge clk);
    io_wr = 1'b0; io_addr = 8'h08; io_wdata = 32'h1234_5678;
    #2 chk("R9 idle", {31'd0, pm_we}, 32'd0);
    @(posedge clk); #2 chk("R9 ptr idle", pm_addr, m_ptr);

    // R7: stray addresses with a closing value leave the port open
    for (int a = 0; a < 256; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        io_write(8'(a), 32'h0000_0000, "R7 stray close");
        io_write(8'h08, 32'(a), "R7 still open");
      end
    end

    // R2: single-bit variants of the key close the port
    for (int b = 0; b < 32; b++) begin
      io_write(8'h00, KEY, "R1 reopen");
      io_write(8'h00, KEY ^ (32'd1 << b), "R2 flip");
      io_write(8'h08, 32'hB00B_0000 + b, "R2 closed");
    end

    // R7: stray addresses with the key do not open the port
    io_write(8'h04, 32'h0000_4000, "R3");
    for (int a = 0; a < 256; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        io_write(8'(a), KEY, "R7 stray key");
        io_write(8'h08, 32'(a), "R7 still closed");
      end
    end

    // R1 and R5: open once more and check pointer continuity
    io_write(8'h00, KEY, "R1");
    io_write(8'h08, 32'h7777_7777, "R4");
    chk("R5 step", pm_addr, 32'h0000_4004);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule